// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block takes a window of up to six bytes fetched at the current program counter and splits the instruction found there into its fields. It reports the operation and function nibbles, both register identifiers, a 32-bit constant, the instruction length in bytes, the address of the following instruction, and a flag for encodings the machine does not define. Memory fetch, execution and the register file live elsewhere. The decoder only interprets the bytes it is given.

The first byte alone fixes the layout. Its upper nibble selects one of twelve operation classes, and the class decides two things: whether a register byte follows, and whether a four-byte constant is present. When a constant is present, it starts right after the register byte, or right after the first byte when there is no register byte. The constant is assembled least-significant byte first. Results are registered, so they appear one clock after the window is presented.

Top module: `vlen_decoder`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `dec_vld` is low after that edge and stays low until a window is accepted with `rst_n` high.
- R2: A window presented with `in_vld` high is decoded in exactly one clock. Byte k of the window sits in `in_win[8k+7:8k]`. `dec_code` is byte 0 bits [7:4] and `dec_fn` is byte 0 bits [3:0].
- R3: `dec_len` is 1 for operation codes 0 (nop), 1 (halt), 9 (return) and C to F. It is 2 for codes 2 (register move), 6 (arithmetic), A (push) and B (pop). It is 5 for codes 7 (conditional jump) and 8 (call). It is 6 for codes 3 (immediate load), 4 (store) and 5 (load).
- R4: For codes 2, 3, 4, 5, 6, A and B, `dec_ra` is byte 1 bits [7:4] and `dec_rb` is byte 1 bits [3:0], passed through unchanged. This includes the value 8 that codes 3, A and B carry as an unused register.
- R5: `dec_next_pc` equals the accepted `in_pc` plus `dec_len`, modulo 2^32.
- R6: For codes without a register byte (0, 1, 7, 8, 9 and C to F), both `dec_ra` and `dec_rb` report 8, meaning "no register".
- R7: For codes 3, 4 and 5, `dec_const` is bytes 2..5 read as a little-endian word (byte 2 is the least significant). For codes 7 and 8 it is bytes 1..4 read the same way, an absolute target. For all other codes it is zero.
- R8: Codes C to F raise `dec_bad`.
- R9: `dec_bad` is also raised in three cases: a nonzero function nibble on codes 0 to 5 and 8 to B; a function nibble above 3 on code 6; a function nibble above 6 on code 7. Length, registers and constant are still decoded as R3, R4, R6 and R7 give them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Window and PC are valid this cycle |
| in_pc | input | 32 | Address of byte 0 of the window |
| in_win | input | 48 | Six instruction bytes, byte k at bits [8k+7:8k] |
| dec_vld | output | 1 | Decoded result valid |
| dec_code | output | 4 | Operation nibble |
| dec_fn | output | 4 | Function nibble |
| dec_ra | output | 4 | First register ID, 8 when absent |
| dec_rb | output | 4 | Second register ID, 8 when absent |
| dec_const | output | 32 | Immediate, displacement or jump target |
| dec_len | output | 3 | Instruction length in bytes |
| dec_next_pc | output | 32 | Address of the next sequential instruction |
| dec_bad | output | 1 | Undefined encoding |

## Verification
The bench sends every one of the 256 first-byte values, plus hand-picked encodings with known answers. A decoder that takes the constant from the wrong offset shows up on the jump and call vectors, because their target starts one byte earlier than a displacement does. Negative displacements and a PC just below 2^32 expose a big-endian assembly of the constant and a next-address adder that is too narrow. Function nibbles one past the last defined arithmetic and jump operation, and nonzero nibbles on halt and return, catch an illegal check that looks only at the operation code. A pipeline stage that drops or duplicates a result breaks the queue order.

// File: rtl/vdec_pkg.sv
// Shared encodings for the variable-length instruction decoder.
// Assumes four-bit operation nibbles; codes above OP_POP are undefined.
package vdec_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_HALT  = 4'h1,
        OP_MOVRR = 4'h2,
        OP_MOVIR = 4'h3,
        OP_MOVRM = 4'h4,
        OP_MOVMR = 4'h5,
        OP_ALU   = 4'h6,
        OP_JCC   = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    // Highest function nibble defined for each class that has variants.
    localparam logic [3:0] ALU_FN_MAX = 4'd3;
    localparam logic [3:0] JCC_FN_MAX = 4'd6;

    // Layout of one instruction as implied by its first byte.
    typedef struct packed {
        logic has_regs;     // a register byte follows byte 0
        logic has_const;    // a word-sized constant is present
        logic const_early;  // constant starts at byte 1 instead of byte 2
        logic bad_code;     // operation nibble undefined
        logic bad_fn;       // function nibble undefined for this class
    } shape_t;

endpackage

// File: rtl/idec_classify.sv
// Classifies the first instruction byte: which fields follow, how long
// the instruction is, and whether the encoding is defined.
// Assumes the constant is WORD_BYTES long and the register byte one byte.
module idec_classify
    import vdec_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int LEN_W      = $clog2(WORD_BYTES + 3)
) (
    input  logic [7:0]       op_byte,
    output shape_t           shape,
    output logic [LEN_W-1:0] len
);

    logic [3:0] code;
    logic [3:0] fn;

    assign code = op_byte[7:4];
    assign fn   = op_byte[3:0];

    // Purpose: map the operation nibble to the field layout.
    always_comb begin
        shape = '0;
        case (code)
            OP_NOP, OP_HALT, OP_RET: ;
            OP_MOVRR, OP_ALU, OP_PUSH, OP_POP:
                shape.has_regs = 1'b1;
            OP_MOVIR, OP_MOVRM, OP_MOVMR: begin
                shape.has_regs  = 1'b1;
                shape.has_const = 1'b1;
            end
            OP_JCC, OP_CALL: begin
                shape.has_const   = 1'b1;
                shape.const_early = 1'b1;
            end
            default:
                shape.bad_code = 1'b1;
        endcase
        if (code == OP_ALU)
            shape.bad_fn = (fn > ALU_FN_MAX);
        else if (code == OP_JCC)
            shape.bad_fn = (fn > JCC_FN_MAX);
        else if (!shape.bad_code)
            shape.bad_fn = (fn != 4'h0);
    end

    // Purpose: length is the first byte plus whichever fields are present.
    always_comb begin
        len = LEN_W'(1) + LEN_W'(shape.has_regs)
            + (shape.has_const ? LEN_W'(WORD_BYTES) : LEN_W'(0));
    end

endmodule

// File: rtl/idec_reg_pick.sv
// Extracts the two register identifiers from the register byte, or
// reports the "none" identifier for both when no register byte exists.
// Assumes the register byte holds two REG_ID_W-bit identifiers.
module idec_reg_pick #(
    parameter int REG_ID_W = 4,
    parameter int NO_REG   = 8
) (
    input  logic [2*REG_ID_W-1:0] reg_byte,
    input  logic                  has_regs,
    output logic [REG_ID_W-1:0]   reg_a,
    output logic [REG_ID_W-1:0]   reg_b
);

    // Purpose: pass through the nibbles or substitute the none marker.
    always_comb begin
        if (has_regs) begin
            reg_a = reg_byte[2*REG_ID_W-1:REG_ID_W];
            reg_b = reg_byte[REG_ID_W-1:0];
        end else begin
            reg_a = REG_ID_W'(NO_REG);
            reg_b = REG_ID_W'(NO_REG);
        end
    end

endmodule

// File: rtl/idec_const_pick.sv
// Assembles the little-endian constant from the window, starting at
// byte 1 or byte 2. Returns zero when the instruction carries none.
// Assumes a window of WORD_BYTES + 2 bytes, byte 0 in the low bits.
module idec_const_pick #(
    parameter int WORD_BYTES = 4
) (
    input  logic [8*(WORD_BYTES+2)-1:0] win,
    input  logic                        has_const,
    input  logic                        const_early,
    output logic [8*WORD_BYTES-1:0]     value
);

    localparam int EARLY_OFS = 1;
    localparam int LATE_OFS  = 2;

    // Purpose: each constant byte k comes from window byte offset + k.
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
        logic [7:0] early_b;
        logic [7:0] late_b;
        assign early_b = win[8*(k+EARLY_OFS) +: 8];
        assign late_b  = win[8*(k+LATE_OFS) +: 8];
        assign value[8*k +: 8] = !has_const  ? 8'h00 :
                                 const_early ? early_b : late_b;
    end

endmodule

// File: rtl/vlen_decoder.sv
// Registered decoder for one variable-length instruction per clock.
// Combines first-byte classification, register and constant extraction,
// and next-address calculation, then registers the result.
// Assumes the window always holds enough bytes for the longest form.
module vlen_decoder
    import vdec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int REG_ID_W   = 4,
    parameter int NO_REG     = 8,
    parameter int LEN_W      = $clog2(WORD_BYTES + 3)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [ADDR_W-1:0]           in_pc,
    input  logic [8*(WORD_BYTES+2)-1:0] in_win,
    output logic                        dec_vld,
    output logic [3:0]                  dec_code,
    output logic [3:0]                  dec_fn,
    output logic [REG_ID_W-1:0]         dec_ra,
    output logic [REG_ID_W-1:0]         dec_rb,
    output logic [8*WORD_BYTES-1:0]     dec_const,
    output logic [LEN_W-1:0]            dec_len,
    output logic [ADDR_W-1:0]           dec_next_pc,
    output logic                        dec_bad
);

    localparam int LONG_LEN  = WORD_BYTES + 2;
    localparam int JUMP_LEN  = WORD_BYTES + 1;

    shape_t                    shape;
    logic [LEN_W-1:0]          len_c;
    logic [REG_ID_W-1:0]       ra_c;
    logic [REG_ID_W-1:0]       rb_c;
    logic [8*WORD_BYTES-1:0]   const_c;
    logic [ADDR_W-1:0]         next_pc_c;

    idec_classify #(
        .WORD_BYTES (WORD_BYTES),
        .LEN_W      (LEN_W)
    ) u_classify (
        .op_byte (in_win[7:0]),
        .shape   (shape),
        .len     (len_c)
    );

    idec_reg_pick #(
        .REG_ID_W (REG_ID_W),
        .NO_REG   (NO_REG)
    ) u_regs (
        .reg_byte (in_win[8 +: 2*REG_ID_W]),
        .has_regs (shape.has_regs),
        .reg_a    (ra_c),
        .reg_b    (rb_c)
    );

    idec_const_pick #(
        .WORD_BYTES (WORD_BYTES)
    ) u_const (
        .win         (in_win),
        .has_const   (shape.has_const),
        .const_early (shape.const_early),
        .value       (const_c)
    );

    // Purpose: address of the instruction that follows sequentially.
    always_comb begin
        next_pc_c = in_pc + ADDR_W'(len_c);
    end

    // Purpose: output stage; reset clears valid, accepted windows load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld     <= 1'b0;
            dec_code    <= '0;
            dec_fn      <= '0;
            dec_ra      <= '0;
            dec_rb      <= '0;
            dec_const   <= '0;
            dec_len     <= '0;
            dec_next_pc <= '0;
            dec_bad     <= 1'b0;
        end else begin
            dec_vld <= in_vld;
            if (in_vld) begin
                dec_code    <= in_win[7:4];
                dec_fn      <= in_win[3:0];
                dec_ra      <= ra_c;
                dec_rb      <= rb_c;
                dec_const   <= const_c;
                dec_len     <= len_c;
                dec_next_pc <= next_pc_c;
                dec_bad     <= shape.bad_code | shape.bad_fn;
            end
        end
    end

    // R1: reset drops the valid output after the edge.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !dec_vld);

    // R2: the operation nibble shown is the one accepted a cycle earlier.
    p_code_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> dec_code == $past(in_win[7:4]));

    // R3: only the four legal lengths ever appear.
    p_len_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> (dec_len == LEN_W'(1) || dec_len == LEN_W'(2) ||
                     dec_len == LEN_W'(JUMP_LEN) || dec_len == LEN_W'(LONG_LEN)));

    // R5: next address tracks the accepted PC plus the reported length.
    p_next_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> dec_next_pc == $past(in_pc) + ADDR_W'(dec_len));

    // R6: forms without a register byte report the none marker twice.
    p_no_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_len != LEN_W'(2) && dec_len != LEN_W'(LONG_LEN)) |->
        (dec_ra == REG_ID_W'(NO_REG) && dec_rb == REG_ID_W'(NO_REG)));

    // R8: undefined operation codes are flagged, one byte, no constant.
    p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_code > 4'hB) |->
        (dec_bad && dec_len == LEN_W'(1) && dec_const == '0));

endmodule

// File: tb/test_vlen_decoder.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares each valid output against the head of the queue.
module test_vlen_decoder;

    typedef struct {
        logic [3:0]  code;
        logic [3:0]  fn;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [31:0] cval;
        logic [2:0]  len;
        logic [31:0] npc;
        logic        bad;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [31:0] in_pc;
    logic [47:0] in_win;
    logic        dec_vld;
    logic [3:0]  dec_code;
    logic [3:0]  dec_fn;
    logic [3:0]  dec_ra;
    logic [3:0]  dec_rb;
    logic [31:0] dec_const;
    logic [2:0]  dec_len;
    logic [31:0] dec_next_pc;
    logic        dec_bad;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    vlen_decoder i_vlen_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_vld      (in_vld),
        .in_pc       (in_pc),
        .in_win      (in_win),
        .dec_vld     (dec_vld),
        .dec_code    (dec_code),
        .dec_fn      (dec_fn),
        .dec_ra      (dec_ra),
        .dec_rb      (dec_rb),
        .dec_const   (dec_const),
        .dec_len     (dec_len),
        .dec_next_pc (dec_next_pc),
        .dec_bad     (dec_bad)
    );

    // Reference written from the requirement text, class by class.
    function automatic exp_t predict(input logic [47:0] w, input logic [31:0] pc);
        exp_t e;
        e.code = w[7:4];
        e.fn   = w[3:0];
        e.ra   = 4'd8;
        e.rb   = 4'd8;
        e.cval = 32'h0;
        e.bad  = 1'b0;
        e.len  = 3'd1;
        case (w[7:4])
            4'h0, 4'h1, 4'h9: e.bad = (w[3:0] != 0);
            4'h2, 4'hA, 4'hB: begin
                e.len = 3'd2; e.ra = w[15:12]; e.rb = w[11:8];
                e.bad = (w[3:0] != 0);
            end
            4'h6: begin
                e.len = 3'd2; e.ra = w[15:12]; e.rb = w[11:8];
                e.bad = (w[3:0] > 3);
            end
            4'h3, 4'h4, 4'h5: begin
                e.len = 3'd6; e.ra = w[15:12]; e.rb = w[11:8];
                e.cval = {w[47:40], w[39:32], w[31:24], w[23:16]};
                e.bad = (w[3:0] != 0);
            end
            4'h7: begin
                e.len = 3'd5;
                e.cval = {w[39:32], w[31:24], w[23:16], w[15:8]};
                e.bad = (w[3:0] > 6);
            end
            4'h8: begin
                e.len = 3'd5;
                e.cval = {w[39:32], w[31:24], w[23:16], w[15:8]};
                e.bad = (w[3:0] != 0);
            end
            default: e.bad = 1'b1;
        endcase
        e.npc = pc + 32'(e.len);
        return e;
    endfunction

    // Driver: present one window and queue its expected result.
    task automatic drive(input logic [47:0] w, input logic [31:0] pc);
        @(negedge clk);
        in_vld = 1'b1;
        in_win = w;
        in_pc  = pc;
        sb_q.push_back(predict(w, pc));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    // Monitor: compare each valid result against the queue head.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && dec_vld === 1'b1) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fails++;
                $display("FAIL R2 unexpected result: actual code %h, expected none", dec_code);
            end else begin
                exp_t e;
                bit   bad_any;
                e = sb_q.pop_front();
                bad_any = 0;
                if (dec_code !== e.code || dec_fn !== e.fn) begin
                    bad_any = 1;
                    $display("FAIL R2 code/fn: actual %h/%h, expected %h/%h",
                             dec_code, dec_fn, e.code, e.fn);
                end
                if (dec_len !== e.len) begin
                    bad_any = 1;
                    $display("FAIL R3 length (code %h): actual %0d, expected %0d",
                             e.code, dec_len, e.len);
                end
                if (dec_ra !== e.ra || dec_rb !== e.rb) begin
                    bad_any = 1;
                    $display("FAIL R4/R6 registers (code %h): actual %h,%h, expected %h,%h",
                             e.code, dec_ra, dec_rb, e.ra, e.rb);
                end
                if (dec_next_pc !== e.npc) begin
                    bad_any = 1;
                    $display("FAIL R5 next pc: actual %h, expected %h", dec_next_pc, e.npc);
                end
                if (dec_const !== e.cval) begin
                    bad_any = 1;
                    $display("FAIL R7 constant (code %h): actual %h, expected %h",
                             e.code, dec_const, e.cval);
                end
                if (dec_bad !== e.bad) begin
                    bad_any = 1;
                    $display("FAIL R8/R9 illegal flag (code %h fn %h): actual %b, expected %b",
                             e.code, e.fn, dec_bad, e.bad);
                end
                if (bad_any) n_fails++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired: actual running, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        in_vld = 1'b1;
        in_pc  = 32'h1234;
        in_win = 48'h0000_0000_0030;
        repeat (3) @(negedge clk);
        // R1: inputs offered during reset produce no result.
        n_checks++;
        if (dec_vld !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 valid during reset: actual %b, expected 0", dec_vld);
        end
        rst_n  = 1'b1;
        in_vld = 1'b0;
        idle(2);

        // R4 R7: immediate load, constant 0x0000abcd into register 2.
        drive(48'h0000_abcd_8230, 32'h0000_0100);
        // R4: register move.
        drive(48'h0000_0000_4320, 32'h0000_0106);
        // R7: load with negative displacement, little-endian bytes.
        drive(48'hffff_fff4_1550, 32'h0000_0200);
        // R7: store with positive displacement.
        drive(48'h0000_041c_6440, 32'h0000_0300);
        // R4: arithmetic, every defined function.
        drive(48'h0000_0000_0660, 32'h10);
        drive(48'h0000_0000_1761, 32'h12);
        drive(48'h0000_0000_2562, 32'h14);
        drive(48'h0000_0000_3463, 32'h16);
        // R7: jump and call targets start at byte 1.
        drive(48'h0000_1122_3344_73, 32'h20);
        drive(48'h00aa_0000_0028_80, 32'h30);
        // R6: single-byte forms.
        drive(48'h0000_0000_0000, 32'h40);
        drive(48'h0000_0000_0010, 32'h41);
        drive(48'h0000_0000_0090, 32'h42);
        // R4: push and pop carry 8 as second register.
        drive(48'h0000_0000_28a0, 32'h50);
        drive(48'h0000_0000_28b0, 32'h52);
        // R5: next address wraps past the top of the space.
        drive(48'h0000_0001_8130, 32'hffff_fffe);
        drive(48'h0000_0000_0090, 32'hffff_ffff);
        // R8: undefined operation code.
        drive(48'h1111_1111_11c0, 32'h60);
        drive(48'hffff_ffff_fff7, 32'h61);
        // R9: function nibble just past the defined ranges.
        drive(48'h0000_0000_0164, 32'h70);
        drive(48'h0000_0000_0077, 32'h72);
        drive(48'h0000_0000_0012, 32'h80);
        drive(48'h0000_0000_0099, 32'h82);
        drive(48'h0000_4321_8532, 32'h84);
        idle(1);
        // R3 R8 R9: sweep every first-byte value with a fixed tail.
        for (int b = 0; b < 256; b++) begin
            drive({40'h8877_6655_43, 8'(b)}, 32'h1000 + 32'(b) * 8);
        end
        idle(4);
        // R2: every queued result must have come out exactly once.
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fails++;
            $display("FAIL R2 results missing: actual %0d pending, expected 0", sb_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule